// File: doc/BRIEF.md
# SPI configuration image loader

This block is a hardware sequencer that programs a target device through the target's SPI configuration port. A host raises `start` with the image length and a flag that says whether the request is a partial reconfiguration. The block first checks the request. It then runs a fixed command sequence through a byte-level SPI master, controlling chip select itself:

1. an enable command, with its 32-bit response read back,
2. program-mode entry,
3. one frame-write transaction per 16 bytes of image data,
4. a disable command,
5. a timed pause,
6. a release command.

Image bytes arrive on a valid/ready stream. Each byte goes straight onto the SPI link behind the opcode of its frame.

Before every chip-select transaction, the block asks an external status poller to wait for the target. The poller waits for not-busy, and also for ready before the response read of the enable step. A poller failure stops the sequence at once, with chip select released and a phase-specific error code latched. A `done` or `error` level reports the outcome and holds until the next accepted start. A program-mode flag tells the host whether the target has been left inside its configuration mode.

Top module: `spi_cfg_loader`

## Requirements
- R1: A start with `partial` high sets `error` with `err_code` 1, and issues no poll request and no chip-select assertion.
- R2: A start whose `total_len` is not a multiple of 16 sets `error` with `err_code` 2, and issues no poll and no chip select. A length of zero is accepted and sends no frame.
- R3: Every rising edge of `spi_cs` follows a poll answered without error. A poll answered with `poll_err` aborts the run with `spi_cs` low and `busy` low. The error code depends on the phase of the failed poll: 4 for the enable command or its response read, 5 for mode entry, 6 for a frame, 7 for disable or release.
- R4: The enable step has two chip-select transactions. The first carries the single byte 0x0B. The second is preceded by a poll with `poll_want_ready` high, the only poll with that signal high. It sends 0x01 followed by four bytes of 0x00. If any of the four bytes received during those 0x00 bytes is nonzero, the run ends with `err_code` 3 before mode entry.
- R5: Mode entry is one transaction carrying 0xAE then 0x01. `prog_mode` rises after it completes. `prog_mode` stays high through any later abort and clears only when a release completes.
- R6: The block sends `total_len`/16 frame transactions. Each one carries 0xEE followed by 16 image bytes, in stream order, under one chip-select assertion.
- R7: `in_ready` is high only in a frame's data slot while no SPI byte is in flight. A completed run consumes exactly `total_len` bytes.
- R8: After the disable transaction (single byte 0x0C), `spi_cs` and `poll_req` both stay low for exactly GAP_CYC cycles. GAP_CYC = CLK_HZ/1e6 × GAP_US. Then a poll and the release transaction (single byte 0x23) follow, and `done` is set.
- R9: `busy` is high from an accepted start until `done` or `error`. A start while busy is ignored. `done` and `error` are mutually exclusive levels, and both are cleared by the next accepted start.
- R10: After reset, all outputs are low, including `prog_mode` and `err_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled while idle |
| partial | input | 1 | Request is a partial reconfiguration |
| total_len | input | LEN_W | Image data length in bytes |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte valid |
| in_ready | output | 1 | Image byte accepted this cycle when valid |
| poll_req | output | 1 | Status poll requested (level) |
| poll_want_ready | output | 1 | Poll must also wait for the ready status |
| poll_done | input | 1 | Poll finished (one-cycle pulse) |
| poll_err | input | 1 | Poll timed out or saw a status error, valid with poll_done |
| spi_cs | output | 1 | Chip select, active high |
| spi_start | output | 1 | Start a byte transfer this cycle |
| spi_tx | output | 8 | Byte to send, valid with spi_start |
| spi_done | input | 1 | Byte transfer finished (one-cycle pulse) |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run completed |
| error | output | 1 | Last run failed |
| err_code | output | 3 | Failure cause for the last run |
| prog_mode | output | 1 | Target left in program mode |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and GAP_US = 20, so the pause between disable and release is 20 cycles. At that size the bench can measure the whole gap and compare it with the exact count, rather than only a bound. LEN_W and FRAME_BYTES keep their defaults. Images of up to four frames then exercise the per-frame opcode, the frame count down to zero frames, and the stream order across stalls on both the SPI side and the image side. The models inject a poll failure at each phase and nonzero bytes in the enable response.

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int GAP_US      = 1500,
  parameter int LEN_W       = 16,
  parameter int FRAME_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             partial,
  input  logic [LEN_W-1:0] total_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             poll_req,
  output logic             poll_want_ready,
  input  logic             poll_done,
  input  logic             poll_err,
  output logic             spi_cs,
  output logic             spi_start,
  output logic [7:0]       spi_tx,
  input  logic             spi_done,
  input  logic [7:0]       spi_rx,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [2:0]       err_code,
  output logic             prog_mode
);
  localparam int GAP_RAW = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int FR_LG   = $clog2(FRAME_BYTES);
  localparam int FCNT_W  = LEN_W - FR_LG;
  localparam int IDX_W   = $clog2(FRAME_BYTES + 1);

  localparam logic [2:0] E_PART = 3'd1, E_LEN = 3'd2, E_RESP = 3'd3,
                         E_P_EN = 3'd4, E_P_MODE = 3'd5, E_P_FRAME = 3'd6, E_P_END = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_POLL, ST_XFER, ST_GAP} st_t;
  typedef enum logic [2:0] {PH_EN, PH_RD, PH_MODE, PH_FRAME, PH_DIS, PH_REL} ph_t;

  st_t               st;
  ph_t               ph;
  logic [IDX_W-1:0]  idx, last_idx;
  logic              inflight;
  logic [7:0]        rd_acc;
  logic [FCNT_W-1:0] frames_left;
  logic [GAP_W-1:0]  gap_cnt;
  logic [2:0]        poll_code;
  logic              need_data;

  assign need_data       = (ph == PH_FRAME) && (idx != '0);
  assign spi_start       = (st == ST_XFER) && !inflight && (!need_data || in_valid);
  assign in_ready        = (st == ST_XFER) && !inflight && need_data;
  assign poll_req        = (st == ST_POLL);
  assign poll_want_ready = (ph == PH_RD);
  assign busy            = (st != ST_IDLE);

  always_comb begin
    last_idx  = '0;
    spi_tx    = 8'h00;
    poll_code = E_P_END;
    case (ph)
      PH_EN:    begin spi_tx = 8'h0B; poll_code = E_P_EN; end
      PH_RD:    begin spi_tx = (idx == '0) ? 8'h01 : 8'h00; last_idx = IDX_W'(4); poll_code = E_P_EN; end
      PH_MODE:  begin spi_tx = (idx == '0) ? 8'hAE : 8'h01; last_idx = IDX_W'(1); poll_code = E_P_MODE; end
      PH_FRAME: begin spi_tx = (idx == '0) ? 8'hEE : in_data; last_idx = IDX_W'(FRAME_BYTES); poll_code = E_P_FRAME; end
      PH_DIS:   spi_tx = 8'h0C;
      PH_REL:   spi_tx = 8'h23;
      default:  spi_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_EN; idx <= '0; inflight <= 1'b0; rd_acc <= '0;
      frames_left <= '0; gap_cnt <= '0; spi_cs <= 1'b0;
      done <= 1'b0; error <= 1'b0; err_code <= '0; prog_mode <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          done <= 1'b0; error <= 1'b0; err_code <= '0;
          if (partial) begin
            error <= 1'b1; err_code <= E_PART;
          end else if (total_len[FR_LG-1:0] != '0) begin
            error <= 1'b1; err_code <= E_LEN;
          end else begin
            st <= ST_POLL; ph <= PH_EN;
            frames_left <= total_len[LEN_W-1:FR_LG];
          end
        end
        ST_POLL: if (poll_done) begin
          if (poll_err) begin
            st <= ST_IDLE; error <= 1'b1; err_code <= poll_code;
          end else begin
            st <= ST_XFER; spi_cs <= 1'b1; idx <= '0; rd_acc <= '0;
          end
        end
        ST_XFER: begin
          if (spi_start) inflight <= 1'b1;
          if (inflight && spi_done) begin
            inflight <= 1'b0;
            if (ph == PH_RD && idx != '0) rd_acc <= rd_acc | spi_rx;
            if (idx != last_idx) begin
              idx <= idx + 1'b1;
            end else begin
              spi_cs <= 1'b0;
              st <= ST_POLL;
              case (ph)
                PH_EN: ph <= PH_RD;
                PH_RD: begin
                  if ((rd_acc | spi_rx) != 8'h00) begin
                    st <= ST_IDLE; error <= 1'b1; err_code <= E_RESP;
                  end else ph <= PH_MODE;
                end
                PH_MODE: begin
                  prog_mode <= 1'b1;
                  ph <= (frames_left == '0) ? PH_DIS : PH_FRAME;
                end
                PH_FRAME: begin
                  frames_left <= frames_left - 1'b1;
                  if (frames_left == FCNT_W'(1)) ph <= PH_DIS;
                end
                PH_DIS: begin st <= ST_GAP; gap_cnt <= '0; end
                default: begin
                  st <= ST_IDLE; prog_mode <= 1'b0; done <= 1'b1;
                end
              endcase
            end
          end
        end
        default: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            st <= ST_POLL; ph <= PH_REL;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
      endcase
    end
  end

  // R1
  partial_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && partial) |=> (error && !busy && !spi_cs && err_code == E_PART));
  // R2
  len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !partial && total_len[FR_LG-1:0] != '0) |=> (error && !busy && err_code == E_LEN));
  // R3
  cs_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs) |-> $past(poll_req && poll_done && !poll_err));
  // R3
  poll_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_req && spi_cs));
  // R6
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start) |=> spi_cs);
  // R7
  in_ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (spi_cs && !spi_start || spi_cs && in_valid));
  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R8
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> (!spi_cs && !poll_req && !spi_start));
endmodule

// File: tb/spi_cfg_loader_tb.sv
module spi_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 1_000_000;
  localparam int GAP_US = 20;
  localparam int GAP_CYC = 20;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic        partial;
    logic [15:0] len;
    logic [31:0] rxw;
    logic [7:0]  fail_at;
    logic        stall;
    logic [2:0]  exp_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd32, 32'h0,        8'd255, 1'b0, 3'd1},
    '{1'b0, 16'd20, 32'h0,        8'd255, 1'b0, 3'd2},
    '{1'b0, 16'd32, 32'h0,        8'd255, 1'b0, 3'd0},
    '{1'b0, 16'd0,  32'h0,        8'd255, 1'b0, 3'd0},
    '{1'b0, 16'd48, 32'h00010000, 8'd255, 1'b0, 3'd3},
    '{1'b0, 16'd32, 32'h0,        8'd0,   1'b0, 3'd4},
    '{1'b0, 16'd32, 32'h0,        8'd1,   1'b0, 3'd4},
    '{1'b0, 16'd32, 32'h0,        8'd2,   1'b0, 3'd5},
    '{1'b0, 16'd48, 32'h0,        8'd4,   1'b0, 3'd6},
    '{1'b0, 16'd16, 32'h0,        8'd4,   1'b0, 3'd7},
    '{1'b0, 16'd16, 32'h0,        8'd5,   1'b0, 3'd7},
    '{1'b0, 16'd64, 32'h0,        8'd255, 1'b1, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, partial = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic poll_req, poll_want_ready, poll_done = 1'b0, poll_err = 1'b0;
  logic spi_cs, spi_start, spi_done = 1'b0;
  logic [7:0] spi_tx, spi_rx = '0;
  logic busy, done, error, prog_mode;
  logic [2:0] err_code;

  int checks = 0, fails = 0;
  int fail_at = 255, poll_cnt = 0, poll_base = 0;
  logic want_log [0:63];
  logic [31:0] rxw = '0;
  int cs_rise_cnt = 0, grp_base = 0;
  int log_n = 0;
  int log_g [0:255];
  int log_i [0:255];
  logic [7:0] log_b [0:255];
  int feed_idx = 0, feed_base = 0, feed_len = 0;
  logic stall_en = 1'b0;
  int gap_min = 1000000, gap_max = 0, gap_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_loader #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US), .LEN_W(LEN_W), .FRAME_BYTES(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .total_len(total_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .poll_req(poll_req), .poll_want_ready(poll_want_ready), .poll_done(poll_done), .poll_err(poll_err),
    .spi_cs(spi_cs), .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .busy(busy), .done(done), .error(error), .err_code(err_code), .prog_mode(prog_mode));

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic int glen(input int g, input int f);
    if (g == 1) return 5;
    if (g == 2) return 2;
    if (g >= 3 && g < 3 + f) return 17;
    return 1;
  endfunction

  function automatic logic [7:0] expb(input int g, input int bi, input int f);
    if (g == 0) return 8'h0B;
    if (g == 1) return (bi == 0) ? 8'h01 : 8'h00;
    if (g == 2) return (bi == 0) ? 8'hAE : 8'h01;
    if (g < 3 + f) return (bi == 0) ? 8'hEE : pat((g - 3) * 16 + bi - 1);
    if (g == 3 + f) return 8'h0C;
    return 8'h23;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge spi_cs) cs_rise_cnt++;

  initial begin : spi_model
    int last_abs, bidx, g;
    last_abs = -1; bidx = 0;
    forever begin
      @(negedge clk);
      while (spi_start) begin
        if (cs_rise_cnt != last_abs) begin bidx = 0; last_abs = cs_rise_cnt; end
        else bidx++;
        g = cs_rise_cnt - grp_base - 1;
        if (log_n < 256) begin
          log_g[log_n] = g; log_i[log_n] = bidx; log_b[log_n] = spi_tx;
        end
        log_n++;
        repeat (1 + (log_n % 3)) @(negedge clk);
        spi_rx = (g == 1 && bidx >= 1) ? 8'(rxw >> (8 * (bidx - 1))) : 8'h00;
        spi_done = 1'b1;
        @(negedge clk);
        spi_done = 1'b0; spi_rx = 8'h00;
      end
    end
  end

  initial begin : poll_model
    forever begin
      @(negedge clk);
      if (poll_req) begin
        if (poll_cnt - poll_base < 64) want_log[poll_cnt - poll_base] = poll_want_ready;
        repeat (2) @(negedge clk);
        poll_err = (poll_cnt - poll_base == fail_at);
        poll_done = 1'b1;
        poll_cnt++;
        @(negedge clk);
        poll_done = 1'b0; poll_err = 1'b0;
      end
    end
  end

  initial begin : feeder
    bit fire;
    int cyc;
    cyc = 0;
    forever begin
      @(negedge clk);
      fire = in_valid && in_ready;
      @(posedge clk); #1;
      cyc++;
      if (fire) feed_idx++;
      in_valid = (feed_idx - feed_base < feed_len) && !(stall_en && (cyc % 4 == 1));
      in_data = pat(feed_idx - feed_base);
    end
  end

  initial begin : gap_mon
    int run;
    run = 0;
    forever begin
      @(negedge clk);
      if (busy && !spi_cs && !poll_req) run++;
      else begin
        if (run > 0) begin
          gap_seen++;
          if (run < gap_min) gap_min = run;
          if (run > gap_max) gap_max = run;
        end
        run = 0;
      end
    end
  end

  task automatic run_vec(input vec_t v, input bit poke);
    int f, eg, ep, nb, bad, ebytes, epm, pm_before, polls, wbad;
    string etag;
    f = int'(v.len) / 16;
    partial = v.partial; total_len = v.len; rxw = v.rxw; fail_at = v.fail_at;
    stall_en = v.stall;
    poll_base = poll_cnt; grp_base = cs_rise_cnt;
    feed_base = feed_idx; feed_len = int'(v.len);
    pm_before = prog_mode;
    nb = log_n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      // R9: start while busy is ignored
      chk(busy == 1'b1, "R9 busy during run", busy, 1);
      partial = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0; partial = v.partial;
    end
    while (!(done || error)) @(negedge clk);
    @(negedge clk);
    case (v.exp_err)
      3'd0: begin eg = 5 + f; ep = 5 + f; etag = "R8"; end
      3'd1: begin eg = 0; ep = 0; etag = "R1"; end
      3'd2: begin eg = 0; ep = 0; etag = "R2"; end
      3'd3: begin eg = 2; ep = 2; etag = "R4"; end
      default: begin eg = int'(v.fail_at); ep = int'(v.fail_at) + 1; etag = "R3"; end
    endcase
    chk(err_code == v.exp_err, {etag, " err_code"}, err_code, v.exp_err);
    chk(error == (v.exp_err != 0) && done == (v.exp_err == 0), {etag, " done/error"},
        {done, error}, (v.exp_err == 0) ? 2 : 1);
    chk(busy == 1'b0 && spi_cs == 1'b0, "R3 idle after run", {busy, spi_cs}, 0);
    chk(cs_rise_cnt - grp_base == eg, "R5 transaction count", cs_rise_cnt - grp_base, eg);
    ebytes = 0;
    for (int g = 0; g < eg; g++) ebytes += glen(g, f);
    chk(log_n - nb == ebytes, "R6 byte count", log_n - nb, ebytes);
    bad = 0;
    for (int i = nb; i < log_n && i < 256; i++)
      if (log_b[i] != expb(log_g[i], log_i[i], f)) bad++;
    chk(bad == 0, "R6 byte content mismatches", bad, 0);
    polls = poll_cnt - poll_base;
    chk(polls == ep, "R3 poll count", polls, ep);
    wbad = 0;
    for (int p = 0; p < polls && p < 64; p++) if (want_log[p] != (p == 1)) wbad++;
    chk(wbad == 0, "R4 ready-poll placement", wbad, 0);
    if (v.exp_err == 0) epm = 0;
    else if (eg >= 3) epm = 1;
    else epm = pm_before;
    chk(prog_mode == epm, "R5 prog_mode", prog_mode, epm);
    if (v.exp_err == 0)
      chk(feed_idx - feed_base == int'(v.len), "R7 bytes consumed", feed_idx - feed_base, v.len);
    feed_len = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({busy, done, error, spi_cs, poll_req, in_ready, prog_mode} == 7'b0, "R10 outputs in reset",
        {busy, done, error, spi_cs, poll_req, in_ready, prog_mode}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_code == 3'd0 && !busy && !spi_start, "R10 after reset", err_code, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

    // R9: start pulse with partial during a running sequence has no effect
    run_vec('{1'b0, 16'd16, 32'h0, 8'd255, 1'b0, 3'd0}, 1'b1);

    // R8: every disable-to-release pause is exactly GAP_CYC cycles
    chk(gap_seen > 0, "R8 gap observed", gap_seen, 1);
    chk(gap_min == GAP_CYC, "R8 gap minimum", gap_min, GAP_CYC);
    chk(gap_max == GAP_CYC, "R8 gap maximum", gap_max, GAP_CYC);

    // R2: zero length gives no frame (covered by table), and error clears on next start
    run_vec('{1'b0, 16'd8, 32'h0, 8'd255, 1'b0, 3'd2}, 1'b0);
    run_vec('{1'b0, 16'd16, 32'h0, 8'd255, 1'b1, 3'd0}, 1'b0);
    chk(!error && done, "R9 error cleared by next start", error, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule